// File: doc/BRIEF.md
# Banked Working-Register Data RAM

This block holds a 64-word by 8-bit internal data store. A processor core reaches it in one of two ways. Register-mode accesses name one of eight working registers with a 3-bit index. RAM-mode accesses give a full 6-bit location. A one-bit bank flag decides where the working-register window sits. With the flag clear, the window covers locations 0 to 7. With the flag set, it covers locations 24 to 31. RAM-mode addresses pass through unchanged whatever the flag holds.

The core sets or clears the flag with separate bank-select pulses. An access presented in the same cycle as a bank-select pulse still uses the flag value from before the pulse. Writes are committed at the rising clock edge. Read data is combinational from the mapped location.

The access port follows valid/ready rules. An access is accepted in any cycle where `acc_valid` and `acc_ready` are both high. `acc_ready` is held high whenever the block is out of reset, so the block never applies back-pressure. A requester may present a new access every cycle.

Top module: `wreg_bank_ram`

## Requirements
- R1: After reset the bank flag is 0, so a register-mode access with index i (0..7) reaches location i.
- R2: With the bank flag at 1, a register-mode access with index i reaches location 24+i. Index 0 maps to location 24 and index 7 maps to location 31.
- R3: A RAM-mode access (`acc_reg_mode` = 0) reaches location `acc_addr` exactly, with either flag value.
- R4: An accepted access with `acc_we` = 1 stores `acc_wdata` at the mapped location on the rising edge. In that same cycle `rd_data` still shows the old content; from the next cycle it shows the new value.
- R5: A cycle with `sel_bank1` alone sets the flag, and a cycle with `sel_bank0` alone clears it. A cycle with both asserted, or with neither, leaves the flag unchanged.
- R6: An access in the same cycle as a bank-select pulse is mapped with the flag value from before that pulse.
- R7: A write with `acc_valid` = 0 or `acc_we` = 0 leaves the storage unchanged.
- R8: `acc_ready` is low while `rst_n` is low and high otherwise.
- R9: Bank-select pulses do not change any stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset (clears bank flag only) |
| sel_bank0 | input | 1 | Pulse: select register bank 0 |
| sel_bank1 | input | 1 | Pulse: select register bank 1 |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access can be accepted |
| acc_reg_mode | input | 1 | 1 = register-mode access, 0 = RAM-mode access |
| acc_reg_idx | input | 3 | Working-register index for register mode |
| acc_addr | input | 6 | Location for RAM mode |
| acc_we | input | 1 | Write enable for the access |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data from the mapped location |

## Verification
Read data depends only on the present inputs and the present state. The bench therefore samples it 2 ns after driving each access, inside the same cycle and before the next rising edge. Writes and bank-select pulses take effect on the following rising edge, so each effect is checked by the next vector's same-cycle read. A read in the same cycle as a write or a bank pulse is expected to show the pre-edge value. The reset-clears-flag result is checked in the first cycle after `rst_n` rises.

// File: rtl/wreg_bank_ram_pkg.sv
package wreg_bank_ram_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 6;
  localparam int IDX_W      = 3;
  localparam int BANK1_BASE = 24;

  typedef enum logic {
    MODE_RAM = 1'b0,
    MODE_REG = 1'b1
  } acc_mode_e;
endpackage

// File: rtl/wreg_bank_flag.sv
module wreg_bank_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_b0,
  input  logic sel_b1,
  output logic bank_q
);
  logic bank_d;

  always_comb begin
    bank_d = bank_q;
    if (sel_b1 && !sel_b0)      bank_d = 1'b1;
    else if (sel_b0 && !sel_b1) bank_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= 1'b0;
    else        bank_q <= bank_d;
  end
endmodule

// File: rtl/wreg_addr_map.sv
module wreg_addr_map #(
  parameter int ADDR_W     = 6,
  parameter int IDX_W      = 3,
  parameter int BANK1_BASE = 24
) (
  input  logic              bank,
  input  logic              reg_mode,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] phys
);
  localparam logic [ADDR_W-1:0] BASE1 = ADDR_W'(BANK1_BASE);

  logic [ADDR_W-1:0] idx_ext;
  logic [ADDR_W-1:0] reg_loc;

  assign idx_ext = {{(ADDR_W-IDX_W){1'b0}}, idx};

  generate
    if ((BANK1_BASE % (1 << IDX_W)) == 0) begin : g_or_base
      assign reg_loc = bank ? (BASE1 | idx_ext) : idx_ext;
    end else begin : g_add_base
      assign reg_loc = bank ? (BASE1 + idx_ext) : idx_ext;
    end
  endgenerate

  assign phys = reg_mode ? reg_loc : addr;
endmodule

// File: rtl/wreg_store.sv
module wreg_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[addr] <= wdata;
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/wreg_bank_ram.sv
module wreg_bank_ram
  import wreg_bank_ram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_bank0,
  input  logic              sel_bank1,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              acc_reg_mode,
  input  logic [IDX_W-1:0]  acc_reg_idx,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_we,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data
);
  logic              bank_q;
  logic [ADDR_W-1:0] phys_addr;
  logic              wr_fire;
  acc_mode_e         mode;

  assign acc_ready = rst_n;
  assign mode      = acc_mode_e'(acc_reg_mode);
  assign wr_fire   = acc_valid && acc_ready && acc_we;

  wreg_bank_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_b0 (sel_bank0),
    .sel_b1 (sel_bank1),
    .bank_q (bank_q)
  );

  wreg_addr_map #(
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W),
    .BANK1_BASE (BANK1_BASE)
  ) u_map (
    .bank     (bank_q),
    .reg_mode (mode == MODE_REG),
    .idx      (acc_reg_idx),
    .addr     (acc_addr),
    .phys     (phys_addr)
  );

  wreg_store #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_store (
    .clk   (clk),
    .wr_en (wr_fire),
    .addr  (phys_addr),
    .wdata (acc_wdata),
    .rdata (rd_data)
  );
endmodule

// File: rtl/wreg_bank_ram_chk.sv
module wreg_bank_ram_chk
  import wreg_bank_ram_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sel_b0,
  input logic              sel_b1,
  input logic              bank,
  input logic              reg_mode,
  input logic [IDX_W-1:0]  idx,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] phys,
  input logic              ready
);
  a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b1 && !sel_b0) |=> bank);
  a_r5_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b0 && !sel_b1) |=> !bank);
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b0 == sel_b1) |=> $stable(bank));
  a_r1_bank0_window: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_mode && !bank) |-> (phys == ADDR_W'(idx)));
  a_r2_bank1_window: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_mode && bank) |-> (phys == ADDR_W'(BANK1_BASE) + ADDR_W'(idx)));
  a_r3_direct_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_mode |-> (phys == addr));
  a_r8_ready_up: assert property (@(posedge clk) disable iff (!rst_n)
    ready);
endmodule

bind wreg_bank_ram wreg_bank_ram_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_b0   (sel_bank0),
  .sel_b1   (sel_bank1),
  .bank     (bank_q),
  .reg_mode (acc_reg_mode),
  .idx      (acc_reg_idx),
  .addr     (acc_addr),
  .phys     (phys_addr),
  .ready    (acc_ready)
);

// File: tb/tb_wreg_bank_ram.sv
`timescale 1ns/1ps
module tb_wreg_bank_ram;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_bank0 = 1'b0, sel_bank1 = 1'b0;
  logic       acc_valid = 1'b0, acc_reg_mode = 1'b0, acc_we = 1'b0;
  logic [2:0] acc_reg_idx = '0;
  logic [5:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic       acc_ready;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wreg_bank_ram dut (
    .clk(clk), .rst_n(rst_n), .sel_bank0(sel_bank0), .sel_bank1(sel_bank1),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_reg_mode(acc_reg_mode),
    .acc_reg_idx(acc_reg_idx), .acc_addr(acc_addr), .acc_we(acc_we),
    .acc_wdata(acc_wdata), .rd_data(rd_data)
  );

  typedef struct packed {
    logic       s0;
    logic       s1;
    logic       vld;
    logic       rmode;
    logic [2:0] idx;
    logic [5:0] addr;
    logic       we;
    logic [7:0] wd;
    logic       chk;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b1,1'b1,3'd2,6'd0, 1'b1,8'h11,1'b0,8'h00,4'd4}, // R4 write r2 bank0
    '{1'b0,1'b0,1'b1,1'b0,3'd0,6'd26,1'b1,8'h22,1'b0,8'h00,4'd3}, // R3 write loc26
    '{1'b0,1'b0,1'b1,1'b1,3'd2,6'd0, 1'b0,8'h00,1'b1,8'h11,4'd1}, // R1 r2 -> loc2
    '{1'b0,1'b0,1'b1,1'b0,3'd0,6'd2, 1'b0,8'h00,1'b1,8'h11,4'd3}, // R3 loc2 direct
    '{1'b0,1'b1,1'b1,1'b1,3'd2,6'd0, 1'b0,8'h00,1'b1,8'h11,4'd6}, // R6 old bank used
    '{1'b0,1'b0,1'b1,1'b1,3'd2,6'd0, 1'b0,8'h00,1'b1,8'h22,4'd2}, // R2 r2 -> loc26
    '{1'b0,1'b0,1'b1,1'b1,3'd5,6'd0, 1'b1,8'h33,1'b0,8'h00,4'd2}, // R2 write r5 -> loc29
    '{1'b0,1'b0,1'b1,1'b0,3'd0,6'd29,1'b0,8'h00,1'b1,8'h33,4'd2}, // R2 loc29 holds it
    '{1'b0,1'b0,1'b1,1'b0,3'd0,6'd5, 1'b1,8'h44,1'b0,8'h00,4'd3}, // R3 write loc5 in bank1
    '{1'b0,1'b0,1'b1,1'b0,3'd0,6'd5, 1'b0,8'h00,1'b1,8'h44,4'd3}, // R3 read loc5
    '{1'b0,1'b0,1'b0,1'b1,3'd5,6'd0, 1'b1,8'h55,1'b0,8'h00,4'd7}, // R7 write, valid low
    '{1'b0,1'b0,1'b1,1'b1,3'd5,6'd0, 1'b0,8'h00,1'b1,8'h33,4'd7}, // R7 unchanged
    '{1'b0,1'b0,1'b1,1'b1,3'd5,6'd0, 1'b0,8'h66,1'b1,8'h33,4'd7}, // R7 we low
    '{1'b0,1'b0,1'b1,1'b1,3'd5,6'd0, 1'b0,8'h00,1'b1,8'h33,4'd7}, // R7 unchanged
    '{1'b1,1'b1,1'b1,1'b1,3'd2,6'd0, 1'b0,8'h00,1'b1,8'h22,4'd5}, // R5 both pulses
    '{1'b0,1'b0,1'b1,1'b1,3'd2,6'd0, 1'b0,8'h00,1'b1,8'h22,4'd5}, // R5 flag held at 1
    '{1'b1,1'b0,1'b1,1'b1,3'd2,6'd0, 1'b0,8'h00,1'b1,8'h22,4'd6}, // R6 old bank used
    '{1'b0,1'b0,1'b1,1'b1,3'd2,6'd0, 1'b0,8'h00,1'b1,8'h11,4'd5}, // R5 cleared
    '{1'b0,1'b0,1'b1,1'b0,3'd0,6'd26,1'b0,8'h00,1'b1,8'h22,4'd9}, // R9 contents kept
    '{1'b0,1'b0,1'b1,1'b1,3'd2,6'd0, 1'b1,8'h77,1'b1,8'h11,4'd4}, // R4 old value pre-edge
    '{1'b0,1'b0,1'b1,1'b1,3'd2,6'd0, 1'b0,8'h00,1'b1,8'h77,4'd4}  // R4 new value
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic s0, input logic s1, input logic vld, input logic rm,
                       input logic [2:0] idx, input logic [5:0] ad, input logic we,
                       input logic [7:0] wd);
    @(negedge clk);
    sel_bank0 = s0; sel_bank1 = s1; acc_valid = vld; acc_reg_mode = rm;
    acc_reg_idx = idx; acc_addr = ad; acc_we = we; acc_wdata = wd;
    #2;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8: ready low in reset
    #25;
    check("R8 ready in reset", {7'd0, acc_ready}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    #2;
    check("R8 ready after reset", {7'd0, acc_ready}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].s0, VEC[i].s1, VEC[i].vld, VEC[i].rmode, VEC[i].idx,
            VEC[i].addr, VEC[i].we, VEC[i].wd);
      if (VEC[i].chk)
        check($sformatf("R%0d vec%0d", VEC[i].req, i), rd_data, VEC[i].exp);
    end

    // R1: reset clears bank flag (set bank1 first)
    drive(1'b0, 1'b1, 1'b0, 1'b1, 3'd2, 6'd0, 1'b0, 8'h00);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 6'd0, 1'b0, 8'h00);
    check("R2 bank1 before reset", rd_data, 8'h22);
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 6'd0, 1'b0, 8'h00);
    check("R1 flag cleared by reset", rd_data, 8'h77);

    // R2 window edges: idx0 -> 24, idx7 -> 31
    drive(1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 6'd24, 1'b1, 8'h5a);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 6'd31, 1'b1, 8'h99);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 6'd0, 1'b0, 8'h00);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 6'd0, 1'b0, 8'h00);
    check("R2 idx0 -> loc24", rd_data, 8'h5a);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 3'd7, 6'd0, 1'b0, 8'h00);
    check("R2 idx7 -> loc31", rd_data, 8'h99);

    // R3: top location reachable in bank1
    drive(1'b0, 1'b0, 1'b1, 1'b0, 3'd7, 6'd63, 1'b1, 8'hc3);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 3'd7, 6'd63, 1'b0, 8'h00);
    check("R3 loc63", rd_data, 8'hc3);

    drive(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 6'd0, 1'b0, 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule